// File: doc/BRIEF.md
# Shrinking and Self-Shrinking Keystream Generator

This block turns linear feedback shift registers into a decimated pseudorandom bit stream. In shrinking mode two registers run side by side. A narrow selector register decides, on every step, whether the current bit of a wider data register goes out or is thrown away. In self-shrinking mode the selector is parked. The data register alone supplies both the decision and the payload: it moves two positions per decision and examines the pair of bits it passes over.

Bits appear at an irregular rate. For that reason the output is a data bit paired with a one-cycle valid strobe. Downstream logic must capture the bit in the cycle the strobe is high. The data bit keeps its last value between strobes.

Software or a key schedule loads both registers through seed inputs. A seed of all zeros would lock a register. Any such seed is replaced by a fixed nonzero fill value. Each enabled clock makes one decision. The mode input is sampled on every enabled clock, so the mode may change between any two steps.

Top module: `shrink_keystream_gen`

## Requirements
- R1: While reset is asserted, and on the cycles after it, `out_valid` and `out_bit` read 0. Both registers start from their fill values. With the default parameters the selector fill is 7'h01 and the data fill is 9'h001.
- R2: `load` writes `seed_sel` into the selector and `seed_dat` into the data register. It takes priority over `en`, and `out_valid` is 0 in the cycle after a load.
- R3: A seed that is all zeros is replaced by that register's fill value. Each register is judged on its own seed.
- R4: One register step moves every bit down one place. Bit 0 is the register's output. The new top bit is the parity of the state ANDed with the tap mask. The default tap masks are 7'h41 for the selector and 9'h021 for the data register. In shrinking mode (`mode` = 0), both registers step once on each enabled cycle.
- R5: In shrinking mode, a step emits the data register's bit 0 when the selector's bit 0 is 1. When the selector's bit 0 is 0, the step emits nothing.
- R6: In self-shrinking mode (`mode` = 1), the data register steps twice per enabled cycle and the selector holds its state. When data bit 0 is 1, bit 1 is emitted. Otherwise nothing is emitted.
- R7: `out_valid` is high for exactly one cycle per emitted bit, in the cycle after the enabled clock that made the decision.
- R8: `out_bit` keeps its previous value whenever `out_valid` is 0.
- R9: With `en` low and no load, neither register moves and `out_valid` is 0.
- R10: A mode change between cycles continues from the registers' current states, with no reseed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load | input | 1 | Seed load strobe |
| seed_sel | input | SEL_W | Selector register seed |
| seed_dat | input | DAT_W | Data register seed |
| en | input | 1 | Step enable, one decision per high cycle |
| mode | input | 1 | 0 selects shrinking, 1 selects self-shrinking |
| out_bit | output | 1 | Emitted keystream bit, held between strobes |
| out_valid | output | 1 | One-cycle strobe marking a new `out_bit` |

## Verification
Properties are checked on every cycle. Both registers must never reach the all-zero state. A register that is not told to move must hold. The selector must stay still during self-shrinking steps. A strobe must trace back to an enabled, non-load clock, and a load must be followed by a quiet cycle. The data bit must not change while the strobe is low. Only the bench's scenarios can show that the emitted bit sequence matches the decimation rules. They compare the output against an arithmetic model of both registers over several hundred steps, across both modes, sparse enables, mid-run mode changes and zero seeds.

// File: rtl/shrink_pkg.sv
package shrink_pkg;

  typedef enum logic {
    GEN_SHRINK = 1'b0,
    GEN_SELF   = 1'b1
  } gen_mode_e;

endpackage

// File: rtl/shrink_rst_sync.sv
module shrink_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = chain_q[STAGES-1];

endmodule

// File: rtl/shrink_lfsr_reg.sv
module shrink_lfsr_reg #(
  parameter int           W     = 9,
  parameter logic [W-1:0] TAPS  = 9'h021,
  parameter logic [W-1:0] FILL  = 9'h001
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic         adv1,
  input  logic         adv2,
  output logic         lead,
  output logic         follow
);

  localparam int DEPTH = 2;

  logic [W-1:0] state_q;
  logic [W-1:0] state_d;
  logic         upd;
  logic [W-1:0] stage [0:DEPTH];

  assign stage[0] = state_q;

  genvar k;
  generate
    for (k = 1; k <= DEPTH; k++) begin : g_step
      assign stage[k] = {^(stage[k-1] & TAPS), stage[k-1][W-1:1]};
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    if (load)      state_d = (seed == '0) ? FILL : seed;
    else if (adv2) state_d = stage[2];
    else if (adv1) state_d = stage[1];
  end

  assign upd = load | adv1 | adv2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   state_q <= FILL;
    else if (upd) state_q <= state_d;
  end

  assign lead   = state_q[0];
  assign follow = state_q[1];

  // R3: the zero-seed substitution and the taps keep the register out of the lockup state
  p_never_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);

  // R9: a register that is neither loaded nor advanced keeps its state
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv1 && !adv2) |=> $stable(state_q));

endmodule

// File: rtl/shrink_select.sv
module shrink_select
  import shrink_pkg::*;
(
  input  logic      en,
  input  logic      load,
  input  gen_mode_e mode,
  input  logic      sel_lead,
  input  logic      dat_lead,
  input  logic      dat_follow,
  output logic      sel_adv,
  output logic      dat_adv1,
  output logic      dat_adv2,
  output logic      keep,
  output logic      kept_bit
);

  logic go;

  assign go = en & ~load;

  always_comb begin
    sel_adv  = 1'b0;
    dat_adv1 = 1'b0;
    dat_adv2 = 1'b0;
    keep     = 1'b0;
    kept_bit = dat_lead;
    unique case (mode)
      GEN_SHRINK: begin
        sel_adv  = go;
        dat_adv1 = go;
        keep     = go & sel_lead;
        kept_bit = dat_lead;
      end
      GEN_SELF: begin
        dat_adv2 = go;
        keep     = go & dat_lead;
        kept_bit = dat_follow;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/shrink_emit.sv
module shrink_emit (
  input  logic clk,
  input  logic rst_n,
  input  logic keep,
  input  logic kept_bit,
  output logic out_bit,
  output logic out_valid
);

  logic bit_q;
  logic vld_q;
  logic bit_d;

  always_comb begin
    bit_d = bit_q;
    if (keep) bit_d = kept_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= keep;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bit_q <= 1'b0;
    else if (keep) bit_q <= bit_d;
  end

  assign out_bit   = bit_q;
  assign out_valid = vld_q;

  // R8: without a strobe the data bit does not move
  p_bit_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q |-> $stable(bit_q));

endmodule

// File: rtl/shrink_keystream_gen.sv
module shrink_keystream_gen
  import shrink_pkg::*;
#(
  parameter int               SEL_W    = 7,
  parameter int               DAT_W    = 9,
  parameter logic [SEL_W-1:0] SEL_TAPS = 7'h41,
  parameter logic [DAT_W-1:0] DAT_TAPS = 9'h021,
  parameter logic [SEL_W-1:0] SEL_FILL = 7'h01,
  parameter logic [DAT_W-1:0] DAT_FILL = 9'h001,
  parameter int               RST_SYNC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SEL_W-1:0] seed_sel,
  input  logic [DAT_W-1:0] seed_dat,
  input  logic             en,
  input  logic             mode,
  output logic             out_bit,
  output logic             out_valid
);

  logic      rst_q_n;
  logic      sel_lead, sel_follow;
  logic      dat_lead, dat_follow;
  logic      sel_adv, dat_adv1, dat_adv2;
  logic      keep, kept_bit;
  gen_mode_e mode_e;

  assign mode_e = gen_mode_e'(mode);

  shrink_rst_sync #(.STAGES(RST_SYNC)) rst_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  shrink_lfsr_reg #(.W(SEL_W), .TAPS(SEL_TAPS), .FILL(SEL_FILL)) sel_reg_i (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .load   (load),
    .seed   (seed_sel),
    .adv1   (sel_adv),
    .adv2   (1'b0),
    .lead   (sel_lead),
    .follow (sel_follow)
  );

  shrink_lfsr_reg #(.W(DAT_W), .TAPS(DAT_TAPS), .FILL(DAT_FILL)) dat_reg_i (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .load   (load),
    .seed   (seed_dat),
    .adv1   (dat_adv1),
    .adv2   (dat_adv2),
    .lead   (dat_lead),
    .follow (dat_follow)
  );

  shrink_select sel_i (
    .en         (en),
    .load       (load),
    .mode       (mode_e),
    .sel_lead   (sel_lead),
    .dat_lead   (dat_lead),
    .dat_follow (dat_follow),
    .sel_adv    (sel_adv),
    .dat_adv1   (dat_adv1),
    .dat_adv2   (dat_adv2),
    .keep       (keep),
    .kept_bit   (kept_bit)
  );

  shrink_emit emit_i (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .keep      (keep),
    .kept_bit  (kept_bit),
    .out_bit   (out_bit),
    .out_valid (out_valid)
  );

  // R7: every strobe follows an enabled clock that was not a load
  p_valid_cause_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_valid |-> ($past(en) && !$past(load)));

  // R2: a load is followed by a quiet cycle
  p_load_quiet_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    load |=> !out_valid);

  // R6: the selector is parked during self-shrinking steps
  p_sel_parked_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (en && !load && mode) |=> $stable({sel_follow, sel_lead}));

endmodule

// File: tb/shrink_keystream_gen_tb.sv
module shrink_keystream_gen_tb_top;

  localparam logic [6:0] S_TAPS = 7'h41;
  localparam logic [8:0] D_TAPS = 9'h021;
  localparam logic [6:0] S_FILL = 7'h01;
  localparam logic [8:0] D_FILL = 9'h001;

  logic       clk;
  logic       rst_n;
  logic       load;
  logic [6:0] seed_sel;
  logic [8:0] seed_dat;
  logic       en;
  logic       mode;
  logic       out_bit;
  logic       out_valid;

  int checks;
  int fails;

  logic [6:0] ms;
  logic [8:0] md;
  logic       ev;
  logic       eb;

  shrink_keystream_gen dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .seed_sel  (seed_sel),
    .seed_dat  (seed_dat),
    .en        (en),
    .mode      (mode),
    .out_bit   (out_bit),
    .out_valid (out_valid)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [6:0] s_step(input logic [6:0] s);
    return {^(s & S_TAPS), s[6:1]};
  endfunction

  function automatic logic [8:0] d_step(input logic [8:0] s);
    return {^(s & D_TAPS), s[8:1]};
  endfunction

  task automatic check(input string tag);
    checks++;
    if (out_valid !== ev || out_bit !== eb) begin
      fails++;
      $display("FAIL %s: valid/bit actual %b/%b expected %b/%b", tag, out_valid, out_bit, ev, eb);
    end
  endtask

  // called just after a falling edge; checks at the next falling edge
  task automatic step_cycle(input logic e, input logic m, input logic ld,
                            input logic [6:0] sa, input logic [8:0] sb, input string tag);
    en = e; mode = m; load = ld; seed_sel = sa; seed_dat = sb;
    if (ld) begin
      ms = (sa == '0) ? S_FILL : sa;
      md = (sb == '0) ? D_FILL : sb;
      ev = 1'b0;
    end else if (e) begin
      if (!m) begin
        ev = ms[0];
        if (ms[0]) eb = md[0];
        ms = s_step(ms);
        md = d_step(md);
      end else begin
        ev = md[0];
        if (md[0]) eb = md[1];
        md = d_step(d_step(md));
      end
    end else begin
      ev = 1'b0;
    end
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    checks = 0; fails = 0;
    rst_n = 1'b0; load = 1'b0; en = 1'b0; mode = 1'b0;
    seed_sel = '0; seed_dat = '0;
    ms = S_FILL; md = D_FILL; ev = 1'b0; eb = 1'b0;

    // R1: quiet outputs during reset
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step_cycle(1'b0, 1'b0, 1'b0, '0, '0, "R1");

    // R1 R4 R5: shrinking from the fill values
    for (int i = 0; i < 250; i++) step_cycle(1'b1, 1'b0, 1'b0, '0, '0, "R5");

    // R2: load while enabled, then shrinking from the seeds
    step_cycle(1'b1, 1'b0, 1'b1, 7'h5A, 9'h1C3, "R2");
    for (int i = 0; i < 220; i++) step_cycle(1'b1, 1'b0, 1'b0, '0, '0, "R4");

    // R3: zero seeds fall back to the fills, one register at a time
    step_cycle(1'b0, 1'b0, 1'b1, 7'h00, 9'h0B7, "R3");
    for (int i = 0; i < 60; i++) step_cycle(1'b1, 1'b0, 1'b0, '0, '0, "R3");
    step_cycle(1'b1, 1'b1, 1'b1, 7'h33, 9'h000, "R3");
    for (int i = 0; i < 60; i++) step_cycle(1'b1, 1'b1, 1'b0, '0, '0, "R3");

    // R6 R7: self-shrinking over a long run
    step_cycle(1'b0, 1'b1, 1'b1, 7'h2C, 9'h155, "R6");
    for (int i = 0; i < 260; i++) step_cycle(1'b1, 1'b1, 1'b0, '0, '0, "R6");

    // R10: switch modes mid-stream; the selector picks up where it was parked
    for (int i = 0; i < 120; i++) step_cycle(1'b1, (i % 7) >= 4, 1'b0, '0, '0, "R10");

    // R8 R9: sparse enables in both modes keep the bit and the registers still
    for (int i = 0; i < 150; i++) step_cycle((i % 3) == 0, 1'b0, 1'b0, '0, '0, "R9");
    for (int i = 0; i < 150; i++) step_cycle((i % 4) == 1, 1'b1, 1'b0, '0, '0, "R8");

    // R7: idle then a single step in each mode
    step_cycle(1'b0, 1'b0, 1'b0, '0, '0, "R7");
    for (int i = 0; i < 40; i++) step_cycle(1'b1, i[0], 1'b0, '0, '0, "R7");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule